// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses which interrupt request, if any, goes to the processor core at each instruction boundary. The sources are a parameterised set. The lowest-numbered sources come from external pins, which are active low. The other sources are peripheral request lines. Each source has an enable bit and a two-bit priority level. The level is built from one bit in a low priority vector and one bit in a high priority vector, so there are four levels.

The controller keeps one in-service bit per level. A grant sets the bit for the granted level. A return-from-interrupt pulse from the core clears the highest set bit. A new request is granted only when its level is strictly above the highest level currently in service. Among requests at the winning level, a fixed rank decides: the lowest source index wins. The external pins are sampled into registers. Each pin is then treated as a level request or as an edge-latched flag. A wake output tells the power manager that an enabled external request is active during a low-power state.

Top module: `nip_ctrl`

## Requirements
- R1: The level of source i is {prio_hi[i], prio_lo[i]} (0 to 3). When enabled requests at different levels are pending at a boundary, the request at the highest level is granted.
- R2: When several enabled pending requests share the highest level, the one with the lowest source index is granted. Source index 0..NUM_EXT-1 are the pins, and index NUM_EXT+k is periph_req[k].
- R3: A request is granted only when its level is strictly greater than the highest level in service, or when no level is in service. While level 3 is in service, nothing is granted.
- R4: A grant happens only in a cycle where insn_boundary and global_en are both 1. Sources whose src_en bit is 0 are never granted.
- R5: A grant sets the in-service bit of its level. A reti pulse clears the highest set in-service bit. A reti and a boundary in the same cycle apply the reti first.
- R6: In level mode (ext_edge_mode[i]=0), pin i requests while its registered sample is low. The pin is sampled one clock before it is used, and no flag is kept.
- R7: In edge mode (ext_edge_mode[i]=1), a flag is set when one registered sample is high and the next is low. The flag is the request and stays set until that source is granted; the grant clears it. A pin held low produces one request.
- R8: wake is 1 exactly when sleep is 1 and at least one external source is enabled with its request active. It is independent of global_en.
- R9: irq_req is high for one cycle, in the cycle after a granting clock edge, and irq_idx carries the granted source index in that cycle. irq_req is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | NUM_EXT | External interrupt pins, active low |
| ext_edge_mode | input | NUM_EXT | Per-pin mode: 1 edge, 0 level |
| periph_req | input | NUM_SRC-NUM_EXT | Peripheral request lines, active high |
| src_en | input | NUM_SRC | Per-source enable |
| prio_lo | input | NUM_SRC | Low bit of each source level |
| prio_hi | input | NUM_SRC | High bit of each source level |
| global_en | input | 1 | Gates all grants |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| sleep | input | 1 | Core is in Idle or Power-down |
| irq_req | output | 1 | Grant strobe to the core |
| irq_idx | output | $clog2(NUM_SRC) | Index of the granted source |
| wake | output | 1 | Wake-up request for low-power states |

## Verification
The bench goes after ties inside one level. An arbiter that ranked by index across levels would pick the wrong source in those cases. It also checks that requests at equal and lower levels stay blocked while a routine is in service, and that level 3 cannot be preempted; a comparison using greater-or-equal would let these requests through. It holds edge-mode pins low to catch a flag that is not cleared on grant, which would give repeated grants. It holds level-mode pins low to catch a latched level request, which would fire once and then stop. The reti-with-boundary cycle is driven to catch ordering errors, and the wake output is exercised with enables toggled.

// File: rtl/nip_pkg.sv
package nip_pkg;
   localparam int NIP_LEVELS = 4;
   typedef logic [1:0] nip_lvl_t;

   // returns {valid, level} of the highest set in-service bit
   function automatic logic [2:0] nip_top_level(input logic [NIP_LEVELS-1:0] isr);
      logic [2:0] r;
      r = 3'b000;
      for (int l = 0; l < NIP_LEVELS; l++) begin
         if (isr[l]) r = {1'b1, 2'(l)};
      end
      return r;
   endfunction
endpackage

// File: rtl/nip_ext_cond.sv
module nip_ext_cond #(
   parameter int NUM_EXT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] pin_n,
   input  logic [NUM_EXT-1:0] edge_mode,
   input  logic [NUM_EXT-1:0] clr,
   output logic [NUM_EXT-1:0] req
);
   genvar p;
   generate
      for (p = 0; p < NUM_EXT; p++) begin : g_pin
         logic smp_now;
         logic smp_old;
         logic flag;
         logic fall;

         assign fall = smp_old & ~smp_now;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               smp_now <= 1'b1;
               smp_old <= 1'b1;
               flag    <= 1'b0;
            end else begin
               smp_now <= pin_n[p];
               smp_old <= smp_now;
               if (!edge_mode[p])  flag <= 1'b0;
               else if (fall)      flag <= 1'b1;
               else if (clr[p])    flag <= 1'b0;
            end
         end

         assign req[p] = edge_mode[p] ? flag : ~smp_now;
      end
   endgenerate
endmodule

// File: rtl/nip_arbiter.sv
module nip_arbiter
   import nip_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] prio_lo,
   input  logic [NUM_SRC-1:0] prio_hi,
   output logic               any,
   output logic [IDX_W-1:0]   win_idx,
   output nip_lvl_t           win_lvl
);
   logic [NIP_LEVELS-1:0][NUM_SRC-1:0] hit;

   genvar l, i;
   generate
      for (l = 0; l < NIP_LEVELS; l++) begin : g_lvl
         for (i = 0; i < NUM_SRC; i++) begin : g_src
            assign hit[l][i] = pend[i] && ({prio_hi[i], prio_lo[i]} == nip_lvl_t'(l));
         end
      end
   endgenerate

   always_comb begin
      any     = 1'b0;
      win_lvl = '0;
      win_idx = '0;
      for (int k = 0; k < NIP_LEVELS; k++) begin
         if (|hit[k]) begin
            any     = 1'b1;
            win_lvl = nip_lvl_t'(k);
         end
      end
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
         if (hit[win_lvl][s]) win_idx = IDX_W'(s);
      end
   end
endmodule

// File: rtl/nip_level_track.sv
module nip_level_track
   import nip_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  grant,
   input  nip_lvl_t              grant_lvl,
   input  logic                  reti,
   output logic [NIP_LEVELS-1:0] isr_q,
   output logic                  act_valid,
   output nip_lvl_t              act_lvl
);
   logic [2:0]            top_now;
   logic [2:0]            top_after;
   logic [NIP_LEVELS-1:0] isr_eff;

   always_comb begin
      top_now = nip_top_level(isr_q);
      isr_eff = isr_q;
      if (reti && top_now[2]) isr_eff[top_now[1:0]] = 1'b0;
      top_after = nip_top_level(isr_eff);
      act_valid = top_after[2];
      act_lvl   = top_after[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_eff | (grant ? (NIP_LEVELS'(1) << grant_lvl) : '0);
   end
endmodule

// File: rtl/nip_ctrl.sv
module nip_ctrl
   import nip_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int NUM_EXT = 2,
   localparam int IDX_W  = $clog2(NUM_SRC),
   localparam int NUM_PER = NUM_SRC - NUM_EXT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_pin_n,
   input  logic [NUM_EXT-1:0] ext_edge_mode,
   input  logic [NUM_PER-1:0] periph_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] prio_lo,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic               global_en,
   input  logic               insn_boundary,
   input  logic               reti,
   input  logic               sleep,
   output logic               irq_req,
   output logic [IDX_W-1:0]   irq_idx,
   output logic               wake
);
   generate
      if (NUM_EXT < 1)        begin : g_bad_ext  $error("NUM_EXT must be at least 1"); end
      if (NUM_SRC <= NUM_EXT) begin : g_bad_src  $error("NUM_SRC must exceed NUM_EXT"); end
   endgenerate

   logic [NUM_EXT-1:0]    ext_req;
   logic [NUM_EXT-1:0]    ext_clr;
   logic [NUM_SRC-1:0]    pend;
   logic                  any;
   logic [IDX_W-1:0]      win_idx;
   nip_lvl_t              win_lvl;
   logic                  act_valid;
   nip_lvl_t              act_lvl;
   logic [NIP_LEVELS-1:0] isr_q;
   logic                  grant;

   nip_ext_cond #(.NUM_EXT(NUM_EXT)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n), .edge_mode(ext_edge_mode),
      .clr(ext_clr), .req(ext_req)
   );

   assign pend = {periph_req, ext_req} & src_en;

   nip_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .pend(pend), .prio_lo(prio_lo), .prio_hi(prio_hi),
      .any(any), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   assign grant = global_en && insn_boundary && any && (!act_valid || (win_lvl > act_lvl));

   genvar e;
   generate
      for (e = 0; e < NUM_EXT; e++) begin : g_clr
         assign ext_clr[e] = grant && (win_idx == IDX_W'(e));
      end
   endgenerate

   nip_level_track u_lvl (
      .clk(clk), .rst_n(rst_n), .grant(grant), .grant_lvl(win_lvl), .reti(reti),
      .isr_q(isr_q), .act_valid(act_valid), .act_lvl(act_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_idx <= '0;
      end else begin
         irq_req <= grant;
         if (grant) irq_idx <= win_idx;
      end
   end

   assign wake = sleep && |(ext_req & src_en[NUM_EXT-1:0]);
endmodule

// File: rtl/nip_ctrl_chk.sv
module nip_ctrl_chk #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_en,
   input logic               global_en,
   input logic               insn_boundary,
   input logic               reti,
   input logic               sleep,
   input logic               irq_req,
   input logic [IDX_W-1:0]   irq_idx,
   input logic               wake,
   input logic [3:0]         isr_q
);
   AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(insn_boundary && global_en)); // R4
   AST_GRANT_ENABLED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((($past(src_en) >> irq_idx) & NUM_SRC'(1)) != '0)); // R4
   AST_TOP_LEVEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_q[3] && !reti) |=> !irq_req); // R3
   AST_GRANT_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (isr_q != 4'b0000)); // R5
   AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> sleep); // R8
endmodule

bind nip_ctrl nip_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_en(src_en), .global_en(global_en),
   .insn_boundary(insn_boundary), .reti(reti), .sleep(sleep),
   .irq_req(irq_req), .irq_idx(irq_idx), .wake(wake), .isr_q(isr_q)
);

// File: tb/tb_nip_ctrl.sv
module tb_nip_ctrl;
   localparam int NS = 8;
   localparam int NE = 2;
   localparam int NP = NS - NE;
   localparam int IW = $clog2(NS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NE-1:0] ext_pin_n, ext_edge_mode;
   logic [NP-1:0] periph_req;
   logic [NS-1:0] src_en, prio_lo, prio_hi;
   logic global_en, insn_boundary, reti, sleep;
   logic irq_req, wake;
   logic [IW-1:0] irq_idx;

   nip_ctrl #(.NUM_SRC(NS), .NUM_EXT(NE)) dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
      .periph_req(periph_req), .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
      .global_en(global_en), .insn_boundary(insn_boundary), .reti(reti), .sleep(sleep),
      .irq_req(irq_req), .irq_idx(irq_idx), .wake(wake)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state built from the requirements
   logic [NE-1:0] m_s1, m_s2, m_flag;
   logic [3:0]    m_isr;
   logic          m_req;
   logic [IW-1:0] m_idx;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int top_of(input logic [3:0] v);
      int t = -1;
      for (int l = 0; l < 4; l++) if (v[l]) t = l;
      return t;
   endfunction

   function automatic logic [NE-1:0] m_ext_req();
      logic [NE-1:0] r;
      for (int i = 0; i < NE; i++) r[i] = ext_edge_mode[i] ? m_flag[i] : ~m_s1[i];
      return r;
   endfunction

   function automatic logic m_wake();
      return sleep && |(m_ext_req() & src_en[NE-1:0]);
   endfunction

   task automatic model_step();
      logic [NS-1:0] pend;
      int best, idx, act;
      logic [3:0] isr_eff;
      logic g;
      pend = {periph_req, m_ext_req()} & src_en;
      best = -1; idx = 0;
      for (int i = 0; i < NS; i++) begin
         int lv = {prio_hi[i], prio_lo[i]};
         if (pend[i] && lv > best) begin best = lv; idx = i; end
      end
      isr_eff = m_isr;
      if (reti && top_of(m_isr) >= 0) isr_eff[top_of(m_isr)] = 1'b0;
      act = top_of(isr_eff);
      g = global_en && insn_boundary && (best >= 0) && (best > act);
      for (int i = 0; i < NE; i++) begin
         if (!ext_edge_mode[i])           m_flag[i] = 1'b0;
         else if (m_s2[i] && !m_s1[i])    m_flag[i] = 1'b1;
         else if (g && idx == i)          m_flag[i] = 1'b0;
      end
      m_s2 = m_s1;
      m_s1 = ext_pin_n;
      m_isr = isr_eff | (g ? (4'b0001 << best) : 4'b0000);
      m_req = g;
      if (g) m_idx = IW'(idx);
   endtask

   task automatic tick();
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      check("R9 strobe", int'(irq_req), int'(m_req));
      if (m_req) check("R1 R2 winner index", int'(irq_idx), int'(m_idx));
      check("R8 wake", int'(wake), int'(m_wake()));
   endtask

   task automatic set_lvl(input int i, input int l);
      prio_lo[i] = l[0];
      prio_hi[i] = l[1];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cnt0, cnt1;
      void'($urandom(32'h5eed_1234));
      ext_pin_n = '1; ext_edge_mode = '0; periph_req = '0;
      src_en = '1; prio_lo = '0; prio_hi = '0;
      global_en = 1'b1; insn_boundary = 1'b0; reti = 1'b0; sleep = 1'b0;
      m_s1 = '1; m_s2 = '1; m_flag = '0; m_isr = '0; m_req = 1'b0; m_idx = '0;
      repeat (3) @(negedge clk);
      check("R9 reset strobe", int'(irq_req), 0);
      check("R8 reset wake", int'(wake), 0);
      rst_n = 1'b1;

      // R2: tie at level 0 between sources 3 and 5
      periph_req[1] = 1'b1; periph_req[3] = 1'b1; insn_boundary = 1'b1;
      tick();
      check("R2 tie lowest index", int'(irq_idx), 3);
      insn_boundary = 1'b0; reti = 1'b1; tick(); reti = 1'b0;

      // R1: higher level wins over lower index
      set_lvl(5, 2); insn_boundary = 1'b1;
      tick();
      check("R1 higher level grant", int'(irq_idx), 5);
      tick();
      check("R3 equal or lower level blocked", int'(irq_req), 0);
      insn_boundary = 1'b0; reti = 1'b1; tick(); reti = 1'b0;
      periph_req = '0;

      // R3: level 3 cannot be preempted, R5 reti then grant in one cycle
      set_lvl(4, 3); set_lvl(6, 3); periph_req[2] = 1'b1; insn_boundary = 1'b1;
      tick();
      check("R1 level3 grant", int'(irq_idx), 4);
      periph_req[4] = 1'b1;
      tick();
      check("R3 level3 not preempted", int'(irq_req), 0);
      reti = 1'b1;
      tick();
      check("R5 reti before grant", int'(irq_req), 1);
      check("R5 regrant index", int'(irq_idx), 4);
      insn_boundary = 1'b0;
      repeat (2) tick();
      reti = 1'b0; periph_req = '0; prio_lo = '0; prio_hi = '0;

      // R4: global and per-source enables
      global_en = 1'b0; periph_req[0] = 1'b1; insn_boundary = 1'b1;
      tick();
      check("R4 global disable", int'(irq_req), 0);
      global_en = 1'b1; src_en[2] = 1'b0;
      tick();
      check("R4 source disable", int'(irq_req), 0);
      src_en[2] = 1'b1; periph_req = '0;

      // R6 / R7: pin 0 edge mode, pin 1 level mode, both held low
      ext_edge_mode = 2'b01; ext_pin_n = 2'b00; reti = 1'b1;
      cnt0 = 0; cnt1 = 0;
      for (int k = 0; k < 8; k++) begin
         tick();
         if (irq_req && irq_idx == 0) cnt0++;
         if (irq_req && irq_idx == 1) cnt1++;
      end
      check("R7 edge single grant", cnt0, 1);
      check("R6 level repeats", cnt1, 6);

      // R8: wake from the held level pin
      insn_boundary = 1'b0; sleep = 1'b1;
      #1 check("R8 wake asserted", int'(wake), 1);
      src_en[1] = 1'b0;
      #1 check("R8 wake needs enable", int'(wake), 0);
      src_en[1] = 1'b1; ext_pin_n = '1; sleep = 1'b0;
      repeat (4) tick();
      reti = 1'b0;

      // random phase
      for (int c = 0; c < 5000; c++) begin
         for (int i = 0; i < NE; i++) if ($urandom_range(7) == 0) ext_pin_n[i] = ~ext_pin_n[i];
         if ($urandom_range(99) == 0) ext_edge_mode = NE'($urandom);
         for (int i = 0; i < NP; i++) periph_req[i] = ($urandom_range(3) == 0);
         if ($urandom_range(63) == 0) begin
            prio_lo = NS'($urandom); prio_hi = NS'($urandom);
         end
         src_en = NS'($urandom) | NS'($urandom) | NS'($urandom);
         global_en = ($urandom_range(9) != 0);
         insn_boundary = $urandom_range(1);
         reti = ($urandom_range(5) == 0);
         sleep = ($urandom_range(4) == 0);
         tick();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule